// File: doc/BRIEF.md
# UART Receive Front End

This block turns an asynchronous serial line into a queue of received characters. The line is oversampled by a 16x bit-rate tick supplied from outside. Each character is framed according to static configuration inputs: a character length of five to eight bits, an optional parity bit with odd, even or forced-value checking, and a stop bit. The received byte and its error flags are written together as one entry of a 16-deep receive queue.

The surrounding logic reads the queue through a show-ahead port. The head entry is always visible, and a one-cycle read strobe removes it. The block also detects a line held low for longer than a whole character (a break), records characters lost to a full queue, and raises a one-cycle timeout strobe when characters sit unread on a quiet line. A clear input empties the queue without upsetting a character that is still arriving.

Top module: `uart_rx_front`

## Requirements
- R1: The character length code `cfgLen` selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. Data bits above the selected length read as zero in the stored byte.
- R2: Data bits arrive least-significant first, and bit n of the stored byte is the n-th data bit after the start bit.
- R3: With `cfgParEn`=1 one parity bit follows the data. When `cfgParStick`=0, the parity bit must make the count of ones odd (`cfgParEven`=0) or even (`cfgParEven`=1). When `cfgParStick`=1, the parity bit must be 1 (`cfgParEven`=0) or 0 (`cfgParEven`=1). A mismatch sets the entry's parity flag `rdPar`. With `cfgParEn`=0 no parity bit is expected and `rdPar` is 0.
- R4: A stop bit sampled low on a character that is not all zeros stores the character with the framing flag `rdFrm` set. Only one stop bit is checked. The receiver then waits for the line to return high.
- R5: A start bit that is no longer low at its mid-bit sample is a false start: nothing is stored.
- R6: A line held low beyond one full character time stores exactly one entry with `rdBrk`=1, a zero byte and the other flags clear. Nothing more is stored until the line has gone high and a new valid start bit arrives.
- R7: The queue holds at most 16 entries (`fifoLevel` ≤ 16). A character that completes while 16 entries are held is dropped, and the next entry that is stored carries `rdOvr`=1.
- R8: While the queue is not empty and no character has been stored for 32 bit-times (512 ticks), `idleTo` pulses high for exactly one clock cycle.
- R9: A `fifoClr` pulse leaves `fifoLevel` at 0 in the following cycle. A character that is being received at that time is still stored when it completes.
- R10: After reset the queue is empty. Entries leave in arrival order. The head entry is visible on the read port, `rdEn` removes it, and `rdEn` has no effect on an empty queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| rxIn | input | 1 | Serial line, idle high |
| baudTick | input | 1 | One-cycle pulse at 16 times the bit rate |
| cfgLen | input | 2 | Character length code |
| cfgParEn | input | 1 | Parity bit present |
| cfgParEven | input | 1 | Even parity, or forced 0 when stick is set |
| cfgParStick | input | 1 | Parity bit has a fixed value |
| fifoClr | input | 1 | Empty the receive queue |
| rdEn | input | 1 | Remove the head entry |
| rdData | output | 8 | Head entry data byte |
| rdOvr | output | 1 | Head entry overrun flag |
| rdPar | output | 1 | Head entry parity error flag |
| rdFrm | output | 1 | Head entry framing error flag |
| rdBrk | output | 1 | Head entry break flag |
| fifoLevel | output | 5 | Number of entries held, 0 to 16 |
| fifoEmpty | output | 1 | Queue holds no entry |
| idleTo | output | 1 | Line-idle timeout strobe |

## Verification
The overrun case is the hardest to reach from the ports. It takes seventeen full characters sent with no read, then one entry removed to make room, then one more character. Only that last character may carry the overrun flag, and the fifteen entries ahead of it must come out clean. The bench drives this sequence directly, checks the level pinned at 16, and drains the whole queue in order. The break case is reached by holding the line low for thirteen bit-times, which must yield exactly one entry.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  // strobes from the receive sequencer to the datapath
  typedef struct packed {
    logic       clrShift;
    logic       capData;
    logic       capPar;
    logic       push;
    logic       frm;
    logic       brk;
    logic [2:0] idx;
  } rxStb_t;

  // one queue entry
  typedef struct packed {
    logic       brk;
    logic       frm;
    logic       par;
    logic       ovr;
    logic [7:0] data;
  } rxEntry_t;
endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxIn,
  input  logic       baudTick,
  input  logic [1:0] cfgLen,
  input  logic       cfgParEn,
  input  logic       allZero,
  output logic       rxS,
  output rxStb_t     stb
);
  localparam int OW = $clog2(OVS);
  localparam logic [OW-1:0] MID_T  = OW'(OVS/2 - 1);
  localparam logic [OW-1:0] FULL_T = OW'(OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK, S_WAITHI} rxState_t;

  rxState_t  state, nxt;
  logic [1:0] syncQ;
  logic [OW-1:0] tickCnt;
  logic [2:0] bitIdx;
  logic [2:0] lastIdx;
  logic atHalf, atFull;

  assign rxS     = syncQ[1];
  assign lastIdx = 3'd4 + {1'b0, cfgLen};
  assign atHalf  = baudTick && (tickCnt == MID_T);
  assign atFull  = baudTick && (tickCnt == FULL_T);

  always_comb begin
    nxt = state;
    stb = '0;
    stb.idx = bitIdx;
    unique case (state)
      S_IDLE:  if (!rxS) nxt = S_START;
      S_START: if (atHalf) begin
        if (rxS) nxt = S_IDLE;
        else begin
          nxt = S_DATA;
          stb.clrShift = 1'b1;
        end
      end
      S_DATA: if (atFull) begin
        stb.capData = 1'b1;
        if (bitIdx == lastIdx) nxt = cfgParEn ? S_PAR : S_STOP;
      end
      S_PAR: if (atFull) begin
        stb.capPar = 1'b1;
        nxt = S_STOP;
      end
      S_STOP: if (atFull) begin
        if (rxS) begin
          stb.push = 1'b1;
          nxt = S_IDLE;
        end else if (allZero) begin
          nxt = S_BRK;
        end else begin
          stb.push = 1'b1;
          stb.frm  = 1'b1;
          nxt = S_WAITHI;
        end
      end
      S_BRK: begin
        if (rxS) begin
          stb.push = 1'b1;
          stb.frm  = 1'b1;
          nxt = S_IDLE;
        end else if (atFull) begin
          stb.push = 1'b1;
          stb.brk  = 1'b1;
          nxt = S_WAITHI;
        end
      end
      S_WAITHI: if (rxS) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= 2'b11;
      state   <= S_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      syncQ <= {syncQ[0], rxIn};
      state <= nxt;
      if (nxt != state || atFull) tickCnt <= '0;
      else if (baudTick)          tickCnt <= tickCnt + 1'b1;
      if (stb.clrShift)     bitIdx <= '0;
      else if (stb.capData) bitIdx <= bitIdx + 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_dpath.sv
module uart_rx_dpath
  import uart_rx_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int OVS       = 16,
  parameter int IDLE_BITS = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxS,
  input  logic       baudTick,
  input  rxStb_t     stb,
  input  logic       cfgParEn,
  input  logic       cfgParEven,
  input  logic       cfgParStick,
  input  logic       fifoClr,
  input  logic       rdEn,
  output logic       allZero,
  output rxEntry_t   head,
  output logic [$clog2(DEPTH):0] level,
  output logic       idleTo
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;
  localparam int IDLE_TICKS = IDLE_BITS * OVS;
  localparam int TMW = $clog2(IDLE_TICKS + 1);

  logic [7:0] shiftReg;
  logic       parBit, parErr;
  rxEntry_t   mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [LW-1:0] count;
  logic       pendOvr, full, wrOk, doPop;
  logic [TMW-1:0] idleTmr;
  rxEntry_t   newEnt;

  assign allZero = (shiftReg == 8'h00) && !parBit;
  assign parErr  = cfgParStick ? (parBit != !cfgParEven)
                               : ((^shiftReg ^ parBit) != !cfgParEven);
  assign full    = (count == LW'(DEPTH));
  assign wrOk    = stb.push && !full && !fifoClr;
  assign doPop   = rdEn && (count != '0) && !fifoClr;
  assign head    = mem[rdPtr];
  assign level   = count;

  always_comb begin
    newEnt.brk  = stb.brk;
    newEnt.frm  = stb.frm;
    newEnt.par  = !stb.brk && cfgParEn && parErr;
    newEnt.ovr  = pendOvr;
    newEnt.data = stb.brk ? 8'h00 : shiftReg;
  end

  always_ff @(posedge clk) begin
    if (wrOk) mem[wrPtr] <= newEnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      pendOvr  <= 1'b0;
      idleTmr  <= '0;
      idleTo   <= 1'b0;
    end else begin
      if (stb.clrShift) begin
        shiftReg <= '0;
        parBit   <= 1'b0;
      end else begin
        if (stb.capData) shiftReg[stb.idx] <= rxS;
        if (stb.capPar)  parBit <= rxS;
      end

      if (fifoClr) begin
        wrPtr <= '0;
        rdPtr <= '0;
        count <= '0;
      end else begin
        if (wrOk)  wrPtr <= wrPtr + 1'b1;
        if (doPop) rdPtr <= rdPtr + 1'b1;
        count <= count + LW'(wrOk) - LW'(doPop);
      end

      if (stb.push && full) pendOvr <= 1'b1;
      else if (wrOk)        pendOvr <= 1'b0;

      if (fifoClr || wrOk || count == '0) idleTmr <= '0;
      else if (baudTick && idleTmr != TMW'(IDLE_TICKS)) idleTmr <= idleTmr + 1'b1;

      idleTo <= !fifoClr && !wrOk && (count != '0) && baudTick &&
                (idleTmr == TMW'(IDLE_TICKS - 1));
    end
  end
endmodule

// File: rtl/uart_rx_front.sv
module uart_rx_front
  import uart_rx_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int OVS       = 16,
  parameter int IDLE_BITS = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxIn,
  input  logic       baudTick,
  input  logic [1:0] cfgLen,
  input  logic       cfgParEn,
  input  logic       cfgParEven,
  input  logic       cfgParStick,
  input  logic       fifoClr,
  input  logic       rdEn,
  output logic [7:0] rdData,
  output logic       rdOvr,
  output logic       rdPar,
  output logic       rdFrm,
  output logic       rdBrk,
  output logic [4:0] fifoLevel,
  output logic       fifoEmpty,
  output logic       idleTo
);
  localparam int LW = $clog2(DEPTH) + 1;

  rxStb_t   stb;
  rxEntry_t head;
  logic     rxS, allZero;
  logic [LW-1:0] level;

  uart_rx_ctrl #(.OVS(OVS)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .baudTick(baudTick),
    .cfgLen(cfgLen), .cfgParEn(cfgParEn), .allZero(allZero),
    .rxS(rxS), .stb(stb)
  );

  uart_rx_dpath #(.DEPTH(DEPTH), .OVS(OVS), .IDLE_BITS(IDLE_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .rxS(rxS), .baudTick(baudTick), .stb(stb),
    .cfgParEn(cfgParEn), .cfgParEven(cfgParEven), .cfgParStick(cfgParStick),
    .fifoClr(fifoClr), .rdEn(rdEn), .allZero(allZero), .head(head),
    .level(level), .idleTo(idleTo)
  );

  assign rdData    = head.data;
  assign rdOvr     = head.ovr;
  assign rdPar     = head.par;
  assign rdFrm     = head.frm;
  assign rdBrk     = head.brk;
  assign fifoLevel = 5'(level);
  assign fifoEmpty = (level == '0);
endmodule

// File: rtl/uart_rx_front_chk.sv
module uart_rx_front_chk #(
  parameter int DEPTH = 16
) (
  input logic       clk,
  input logic       rstN,
  input logic       fifoClr,
  input logic [4:0] fifoLevel,
  input logic       fifoEmpty,
  input logic       rdBrk,
  input logic [7:0] rdData,
  input logic       idleTo
);
  a_r7_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= 5'(DEPTH));

  a_r10_level_step: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, fifoLevel} <= {1'b0, $past(fifoLevel)} + 6'd1);

  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    fifoClr |=> fifoEmpty);

  a_r6_break_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEmpty && rdBrk) |-> rdData == 8'h00);

  a_r8_to_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    idleTo |-> $past(fifoLevel) != 5'd0);

  a_r8_to_single: assert property (@(posedge clk) disable iff (!rstN)
    idleTo |=> !idleTo);
endmodule

bind uart_rx_front uart_rx_front_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .fifoClr(fifoClr), .fifoLevel(fifoLevel),
  .fifoEmpty(fifoEmpty), .rdBrk(rdBrk), .rdData(rdData), .idleTo(idleTo)
);

// File: tb/sim_uart_rx_front.sv
module sim_uart_rx_front;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLK    = 16 * TICK_DIV;

  logic clk = 1'b0, rstN = 1'b0, rxIn = 1'b1, baudTick = 1'b0;
  logic [1:0] cfgLen = 2'd3;
  logic cfgParEn = 1'b0, cfgParEven = 1'b0, cfgParStick = 1'b0;
  logic fifoClr = 1'b0, rdEn = 1'b0;
  logic [7:0] rdData;
  logic rdOvr, rdPar, rdFrm, rdBrk, fifoEmpty, idleTo;
  logic [4:0] fifoLevel;

  int nChk = 0, nFail = 0, tickDiv = 0;
  int cyc = 0, pushCyc = 0, toCyc = 0, toCnt = 0;
  logic [4:0] prevLevel = '0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_front u0 (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .baudTick(baudTick), .cfgLen(cfgLen),
    .cfgParEn(cfgParEn), .cfgParEven(cfgParEven), .cfgParStick(cfgParStick),
    .fifoClr(fifoClr), .rdEn(rdEn), .rdData(rdData), .rdOvr(rdOvr), .rdPar(rdPar),
    .rdFrm(rdFrm), .rdBrk(rdBrk), .fifoLevel(fifoLevel), .fifoEmpty(fifoEmpty),
    .idleTo(idleTo)
  );

  always @(negedge clk) begin
    if (tickDiv == TICK_DIV - 1) begin tickDiv = 0; baudTick = 1'b1; end
    else begin tickDiv = tickDiv + 1; baudTick = 1'b0; end
    cyc = cyc + 1;
    if (rstN && fifoLevel != 0 && prevLevel == 0) pushCyc = cyc;
    if (rstN && idleTo) begin toCyc = cyc; toCnt = toCnt + 1; end
    prevLevel = fifoLevel;
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sendBit(logic b);
    rxIn = b;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  // frames one character from the bench configuration
  task automatic sendChar(logic [7:0] d, bit badPar = 0, logic stopVal = 1'b1);
    int nb = 5 + int'(cfgLen);
    logic p;
    logic [7:0] m = d & ((8'h1 << nb) - 8'h1);
    p = cfgParStick ? !cfgParEven : ((^m) ^ !cfgParEven);
    sendBit(1'b0);
    for (int i = 0; i < nb; i++) sendBit(d[i]);
    if (cfgParEn) sendBit(p ^ badPar);
    sendBit(stopVal);
    sendBit(1'b1);
    sendBit(1'b1);
  endtask

  task automatic popEntry(output logic [11:0] e);
    @(negedge clk);
    e = {rdBrk, rdFrm, rdPar, rdOvr, rdData};
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic setCfg(logic [1:0] l, logic pe, logic ev, logic st);
    cfgLen = l; cfgParEn = pe; cfgParEven = ev; cfgParStick = st;
  endtask

  task automatic sendCheck(string req, logic [7:0] d, logic [11:0] exp, bit badPar = 0);
    logic [11:0] e;
    sendChar(d, badPar);
    chk(req, "level", 32'(fifoLevel), 32'd1);
    popEntry(e);
    chk(req, "entry", 32'(e), 32'(exp));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R10", "reset level", 32'(fifoLevel), 0);
    chk("R10", "reset empty", 32'(fifoEmpty), 1);
    chk("R8", "reset idleTo", 32'(idleTo), 0);
  endtask

  task automatic t_lengths;
    setCfg(2'd0, 0, 0, 0); sendCheck("R1", 8'hFF, 12'h01F);
    setCfg(2'd1, 0, 0, 0); sendCheck("R1", 8'hEA, 12'h02A);
    setCfg(2'd2, 0, 0, 0); sendCheck("R1", 8'hB3, 12'h033);
    setCfg(2'd3, 0, 0, 0); sendCheck("R2", 8'hA5, 12'h0A5);
    sendCheck("R2", 8'h01, 12'h001);
  endtask

  task automatic t_parity;
    setCfg(2'd3, 1, 0, 0); sendCheck("R3", 8'h3C, 12'h03C);
    setCfg(2'd3, 1, 1, 0); sendCheck("R3", 8'h37, 12'h237, 1);
    sendCheck("R3", 8'h37, 12'h037);
    setCfg(2'd3, 1, 0, 1); sendCheck("R3", 8'h5A, 12'h05A);
    sendCheck("R3", 8'h5A, 12'h25A, 1);
    setCfg(2'd3, 1, 1, 1); sendCheck("R3", 8'hC3, 12'h0C3);
    setCfg(2'd3, 0, 0, 0);
  endtask

  task automatic t_frame;
    logic [11:0] e;
    sendChar(8'h55, 0, 1'b0);
    chk("R4", "level", 32'(fifoLevel), 1);
    popEntry(e);
    chk("R4", "framing entry", 32'(e), 32'h455);
    sendCheck("R4", 8'h96, 12'h096);
  endtask

  task automatic t_false;
    rxIn = 1'b0;
    repeat (5 * TICK_DIV) @(negedge clk);
    rxIn = 1'b1;
    repeat (2 * BIT_CLK) @(negedge clk);
    chk("R5", "false start level", 32'(fifoLevel), 0);
    sendCheck("R5", 8'h81, 12'h081);
  endtask

  task automatic t_break;
    logic [11:0] e;
    rxIn = 1'b0;
    repeat (13 * BIT_CLK) @(negedge clk);
    rxIn = 1'b1;
    repeat (2 * BIT_CLK) @(negedge clk);
    chk("R6", "one break entry", 32'(fifoLevel), 1);
    popEntry(e);
    chk("R6", "break entry", 32'(e), 32'h800);
    sendCheck("R6", 8'h3C, 12'h03C);
  endtask

  task automatic t_overrun;
    logic [11:0] e;
    for (int i = 0; i < 17; i++) sendChar(8'(i));
    chk("R7", "level pinned", 32'(fifoLevel), 16);
    popEntry(e);
    chk("R7", "first entry", 32'(e), 32'h000);
    sendChar(8'h99);
    chk("R7", "level refilled", 32'(fifoLevel), 16);
    for (int i = 1; i < 16; i++) begin
      popEntry(e);
      chk("R7", "drain entry", 32'(e), 32'(i));
    end
    popEntry(e);
    chk("R7", "overrun flagged", 32'(e), 32'h199);
    chk("R7", "drained", 32'(fifoEmpty), 1);
  endtask

  task automatic t_idle;
    int c0 = toCnt;
    logic [11:0] e;
    repeat (3000) @(negedge clk);
    chk("R8", "no strobe when empty", 32'(toCnt - c0), 0);
    sendChar(8'h42);
    repeat (3000) @(negedge clk);
    chk("R8", "one strobe", 32'(toCnt - c0), 1);
    chk("R8", "delay window", 32'((toCyc - pushCyc >= 2040) && (toCyc - pushCyc <= 2056)), 1);
    popEntry(e);
    chk("R8", "entry", 32'(e), 32'h042);
  endtask

  task automatic t_clear;
    logic [11:0] e;
    sendChar(8'h11);
    sendChar(8'h22);
    chk("R9", "prefill", 32'(fifoLevel), 2);
    fork
      sendChar(8'h6B);
      begin
        repeat (4 * BIT_CLK) @(negedge clk);
        fifoClr = 1'b1;
        @(negedge clk);
        fifoClr = 1'b0;
        chk("R9", "cleared", 32'(fifoLevel), 0);
      end
    join
    chk("R9", "in-flight kept", 32'(fifoLevel), 1);
    popEntry(e);
    chk("R9", "in-flight entry", 32'(e), 32'h06B);
  endtask

  task automatic t_order;
    logic [11:0] e;
    @(negedge clk); rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0;
    chk("R10", "pop on empty", 32'(fifoLevel), 0);
    sendChar(8'hC1);
    sendChar(8'h7E);
    chk("R10", "two held", 32'(fifoLevel), 2);
    popEntry(e); chk("R10", "order first", 32'(e), 32'h0C1);
    popEntry(e); chk("R10", "order second", 32'(e), 32'h07E);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_lengths();
    t_parity();
    t_frame();
    t_false();
    t_break();
    t_overrun();
    t_idle();
    t_clear();
    t_order();
    summary();
  end
endmodule